// File: doc/BRIEF.md
# Doorbell Mailbox Register Block

This block is a small register mailbox placed between a host processor and a control microcontroller. The host reaches it through a plain 32-bit register bus with byte addresses. Before it issues a command, the host fills an outbound data buffer. It then writes a command word, which rings a one-cycle doorbell towards the microcontroller. The microcontroller reads the latched command word and the outbound buffer, and it may place response words in an inbound buffer. It then pulses a done strobe, and with that strobe it presents an error flag and an error code.

The host learns that the command has finished by reading a status word, which carries busy, error, the latched command id and an initiator id. If the host set the interrupt-on-completion flag in the command, it can instead wait for a one-cycle interrupt pulse. That pulse needs no clearing. Decoding of message contents is left to firmware. The size field travels with the latched command word and tells the firmware how many outbound bytes belong to the command.

Both buffer ports are plain indexed register accesses that are always accepted. Neither side can stall the other. For that reason the block has no valid/ready pairs and no back-pressure rules.

Top module: `dbmbx_top`

## Requirements
- R1: After reset the status word reads 0 except for the initiator id in bits 15:8. The doorbell, the interrupt and the latched command word are all 0.
- R2: The host writes address 0x00 while busy is clear. The doorbell is then high for exactly the one cycle after that edge. The written word appears on `cmd_word`, busy (status bit 0) reads 1, and status bits 7:4 echo command bits 15:12.
- R3: A write to address 0x00 while busy is set raises no doorbell and leaves `cmd_word` and the status word unchanged.
- R4: Busy stays set until `dev_done` is sampled high, and it reads 0 from the cycle after that edge.
- R5: At the edge where `dev_done` is accepted, status bit 1 takes `dev_err` and status bits 23:16 take `dev_err_code`. An accepted command write clears both fields.
- R6: `host_irq` is a one-cycle pulse in the cycle after `dev_done` is accepted. It occurs only if bit 8 of the latched command word is 1.
- R7: A `dev_done` pulse while busy is clear has no effect on the status word or on `host_irq`.
- R8: A host word write to 0x80+4i stores word i of the outbound buffer, and the device sees that word on `dev_obuf_data` when `dev_obuf_idx` is i.
- R9: Word i of the inbound buffer is written by the device and reads on the host bus at 0x90+4i. For a byte read at 0x90+k, the byte lies in bits 8*(k mod 4)+7:8*(k mod 4). Host writes to 0x90..0x9F have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | 8 | Host byte address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from `hst_addr` |
| dbell | output | 1 | Doorbell pulse to microcontroller |
| cmd_word | output | 32 | Latched command word |
| dev_obuf_idx | input | 2 | Outbound buffer word index |
| dev_obuf_data | output | 32 | Outbound buffer word |
| dev_rsp_we | input | 1 | Inbound buffer write strobe |
| dev_rsp_idx | input | 2 | Inbound buffer word index |
| dev_rsp_data | input | 32 | Inbound buffer write data |
| dev_done | input | 1 | Completion strobe |
| dev_err | input | 1 | Error flag, sampled with done |
| dev_err_code | input | 8 | Error code, sampled with done |
| host_irq | output | 1 | Completion interrupt pulse |

## Verification
The assertions check on every cycle that the doorbell lasts one cycle and only ever accompanies a rise of busy. They also check that busy cannot drop without a done strobe, and that an interrupt pulse follows only a busy-to-idle transition of a command that asked for one. Only the bench's scenarios can show the values involved: the echoed command id and error fields, the effect of ignored writes, and the buffer contents with their byte lanes. The bench sweeps every command id against both completion modes and both error outcomes.

// File: rtl/dbmbx_pkg.sv
package dbmbx_pkg;
  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [3:0] PAGE_OUT = 4'h8;
  localparam logic [3:0] PAGE_RSP = 4'h9;
  localparam int CMD_IOC_BIT = 8;
  localparam int CMD_ID_LSB  = 12;

  function automatic logic [31:0] pack_status(
    input logic       busy,
    input logic       err,
    input logic [3:0] cid,
    input logic [7:0] init_id,
    input logic [7:0] ecode
  );
    return {8'h00, ecode, init_id, cid, 2'b00, err, busy};
  endfunction
endpackage

// File: rtl/dbmbx_wbuf.sv
module dbmbx_wbuf #(
  parameter int WORDS = 4,
  parameter int W     = 32,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [W-1:0]    wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                           mem[g] <= '0;
      else if (we && widx == IDXW'(g))      mem[g] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/dbmbx_ctrl.sv
module dbmbx_ctrl
  import dbmbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_in,
  input  logic        done,
  input  logic        err_in,
  input  logic [7:0]  code_in,
  output logic        busy,
  output logic        err,
  output logic [7:0]  err_code,
  output logic [31:0] cmd_q,
  output logic        dbell,
  output logic        irq
);
  logic accept, finish;
  assign accept = cmd_we && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; err <= 1'b0; err_code <= '0;
      cmd_q <= '0; dbell <= 1'b0; irq <= 1'b0;
    end else begin
      dbell <= accept;
      irq   <= finish && cmd_q[CMD_IOC_BIT];
      if (accept) begin
        busy <= 1'b1; cmd_q <= cmd_in;
        err <= 1'b0;  err_code <= '0;
      end else if (finish) begin
        busy <= 1'b0; err <= err_in; err_code <= code_in;
      end
    end
  end

  // R2
  dbell_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbell |-> busy && !$past(busy));
  // R2
  dbell_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbell |=> !dbell);
  // R3
  no_bell_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_we |=> !dbell);
  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R6
  irq_after_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy && $past(busy) && cmd_q[CMD_IOC_BIT]);
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/dbmbx_top.sv
module dbmbx_top
  import dbmbx_pkg::*;
#(
  parameter int          BUF_BYTES = 16,
  parameter logic [7:0]  INIT_ID   = 8'h5A,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int IDXW  = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      hst_addr,
  input  logic            hst_wr,
  input  logic [31:0]     hst_wdata,
  output logic [31:0]     hst_rdata,
  output logic            dbell,
  output logic [31:0]     cmd_word,
  input  logic [IDXW-1:0] dev_obuf_idx,
  output logic [31:0]     dev_obuf_data,
  input  logic            dev_rsp_we,
  input  logic [IDXW-1:0] dev_rsp_idx,
  input  logic [31:0]     dev_rsp_data,
  input  logic            dev_done,
  input  logic            dev_err,
  input  logic [7:0]      dev_err_code,
  output logic            host_irq
);
  logic busy, err;
  logic [7:0] err_code;
  logic [31:0] rsp_rd;
  logic cmd_we, obuf_we;

  assign cmd_we  = hst_wr && hst_addr == OFS_CMD;
  assign obuf_we = hst_wr && hst_addr[7:4] == PAGE_OUT && hst_addr[1:0] == 2'b00;

  dbmbx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_in(hst_wdata),
    .done(dev_done), .err_in(dev_err), .code_in(dev_err_code),
    .busy(busy), .err(err), .err_code(err_code), .cmd_q(cmd_word),
    .dbell(dbell), .irq(host_irq)
  );

  dbmbx_wbuf #(.WORDS(WORDS), .W(32)) u_obuf (
    .clk(clk), .rst_n(rst_n), .we(obuf_we), .widx(hst_addr[IDXW+1:2]),
    .wdata(hst_wdata), .ridx(dev_obuf_idx), .rdata(dev_obuf_data)
  );

  dbmbx_wbuf #(.WORDS(WORDS), .W(32)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .we(dev_rsp_we), .widx(dev_rsp_idx),
    .wdata(dev_rsp_data), .ridx(hst_addr[IDXW+1:2]), .rdata(rsp_rd)
  );

  always_comb begin
    hst_rdata = '0;
    if (hst_addr == OFS_STAT)
      hst_rdata = pack_status(busy, err, cmd_word[CMD_ID_LSB +: 4], INIT_ID, err_code);
    else if (hst_addr[7:4] == PAGE_RSP)
      hst_rdata = rsp_rd;
  end

  // R7
  idle_done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_we |=> !busy && $stable(err) && $stable(err_code) && !host_irq);
endmodule

// File: tb/dbmbx_top_test.sv
module dbmbx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IID = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic [7:0] hst_addr = 0;
  logic hst_wr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata, cmd_word, dev_obuf_data, dev_rsp_data = 0;
  logic dbell, host_irq, dev_rsp_we = 0, dev_done = 0, dev_err = 0;
  logic [1:0] dev_obuf_idx = 0, dev_rsp_idx = 0;
  logic [7:0] dev_err_code = 0;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbmbx_top uut (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dbell(dbell),
    .cmd_word(cmd_word), .dev_obuf_idx(dev_obuf_idx), .dev_obuf_data(dev_obuf_data),
    .dev_rsp_we(dev_rsp_we), .dev_rsp_idx(dev_rsp_idx), .dev_rsp_data(dev_rsp_data),
    .dev_done(dev_done), .dev_err(dev_err), .dev_err_code(dev_err_code),
    .host_irq(host_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(logic b, logic e, logic [3:0] id, logic [7:0] c);
    return {8'h00, c, IID, id, 2'b00, e, b};
  endfunction

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_wr = 1;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    hst_addr = a; #1; d = hst_rdata;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r, cmd, other;
    logic [3:0] last_id;
    logic [7:0] last_code;
    logic last_err;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    hread(8'h04, r);  chk("R1 status", r, stat(0, 0, 0, 0));
    chk("R1 dbell", dbell, 0);
    chk("R1 irq", host_irq, 0);
    chk("R1 cmd_word", cmd_word, 0);

    last_id = 0; last_code = 0; last_err = 0;
    for (int id = 0; id < 16; id++)
      for (int ioc = 0; ioc < 2; ioc++)
        for (int e = 0; e < 2; e++) begin
          cmd = {8'h00, 8'(id + 1), 4'(id), 3'b000, 1'(ioc), 8'(id * 13 + e)};
          hwrite(8'h00, cmd);
          chk("R2 dbell high", dbell, 1);
          chk("R2 cmd_word", cmd_word, cmd);
          hread(8'h04, r);
          chk("R2 R5 status after write", r, stat(1, 0, 4'(id), 0));
          @(negedge clk);
          chk("R2 dbell single", dbell, 0);
          hread(8'h04, r);  chk("R4 busy held", r[0], 1);
          other = ~cmd;
          hwrite(8'h00, other);
          chk("R3 no dbell", dbell, 0);
          chk("R3 cmd kept", cmd_word, cmd);
          hread(8'h04, r);  chk("R3 status kept", r, stat(1, 0, 4'(id), 0));
          @(negedge clk);
          dev_done = 1; dev_err = 1'(e); dev_err_code = 8'(id) ^ 8'hC3;
          @(negedge clk);
          dev_done = 0; dev_err = 0; dev_err_code = 0;
          hread(8'h04, r);
          chk("R4 R5 status after done", r, stat(0, 1'(e), 4'(id), 8'(id) ^ 8'hC3));
          chk("R6 irq pulse", host_irq, 32'(ioc));
          @(negedge clk);
          chk("R6 irq single", host_irq, 0);
          last_id = 4'(id); last_err = 1'(e); last_code = 8'(id) ^ 8'hC3;
        end

    dev_done = 1; dev_err = ~last_err; dev_err_code = 8'hFF;
    @(negedge clk);
    dev_done = 0; dev_err = 0; dev_err_code = 0;
    hread(8'h04, r);
    chk("R7 status unchanged", r, stat(0, last_err, last_id, last_code));
    chk("R7 no irq", host_irq, 0);

    for (int i = 0; i < 4; i++) hwrite(8'(8'h80 + 4 * i), 32'h1111_0000 * (i + 1) + 32'(i));
    for (int i = 0; i < 4; i++) begin
      dev_obuf_idx = 2'(i); #1;
      chk("R8 obuf word", dev_obuf_data, 32'h1111_0000 * (i + 1) + 32'(i));
    end

    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dev_rsp_we = 1; dev_rsp_idx = 2'(i); dev_rsp_data = 32'hA0B0C0D0 ^ (32'(i) * 32'h01010101);
    end
    @(negedge clk); dev_rsp_we = 0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] w;
      w = 32'hA0B0C0D0 ^ (32'(k / 4) * 32'h01010101);
      hread(8'(8'h90 + k), r);
      chk("R9 rsp byte", 32'(r[8 * (k % 4) +: 8]), 32'(w[8 * (k % 4) +: 8]));
      if (k % 4 == 0) chk("R9 rsp word", r, w);
    end
    hwrite(8'h94, 32'hDEAD_BEEF);
    hread(8'h94, r);
    chk("R9 host write ignored", r, 32'hA0B0C0D0 ^ 32'h01010101);

    finish_run();
  end
endmodule